// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block sits beside the decode stage of a five-stage in-order pipeline. It catches the one data dependence that result forwarding cannot fix. That case arises when the instruction now being decoded reads a register that a load, one stage ahead in execute, has not yet fetched from memory. When the case occurs, the block holds the program counter and the fetch/decode register for one cycle, so the same instruction is fetched and decoded again. In the same cycle it turns the instruction entering execute into a no-operation. One cycle later the load has moved on to the memory stage, and forwarding delivers its value to the waiting instruction.

The hazard decision is combinational. The only state is a small copy of the execute-stage tag: a valid bit, a load flag and a destination register. This copy is loaded from the decode fields on every edge and cleared whenever a bubble is inserted. Because the comparator reads this copy, the block can show the one-cycle length of the stall from its own ports.

Top module: `lu_interlock`

## Requirements
- R1: The block stalls when execute holds a valid load whose destination is non-zero and equal to the decode rs field. The rs field is always treated as read.
- R2: The block stalls when that destination equals the decode rt field, rt is marked as read, and the decode instruction is not a store.
- R3: For a store (decIsStore=1), rt carries the store data and never causes a stall. Only a match on rs stalls a store.
- R4: When decRtUsed=0, the rt field is ignored.
- R5: A load whose destination is register 0 never causes a stall.
- R6: An execute-stage instruction that is invalid, or that is not a load, never causes a stall.
- R7: During a stall, pcWrEn=0, ifIdWrEn=0 and idExBubble=1, all in the same cycle. Without a stall the outputs are 1, 1 and 0.
- R8: A stall lasts exactly one cycle. The bubble empties the execute tag, so holding the same decode inputs over the next edge gives no stall.
- R9: With no stall, the decode instruction's load flag, destination and valid bit reach the execute tag after one clock edge.
- R10: While rstN is low, the execute tag is empty and no stall is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decRs | input | REG_ADDR_W | First source register of the decode instruction |
| decRt | input | REG_ADDR_W | Second source register of the decode instruction |
| decRtUsed | input | 1 | Decode instruction really reads rt |
| decIsStore | input | 1 | Decode instruction is a store (rt is store data) |
| decIsLoad | input | 1 | Decode instruction is a load |
| decRd | input | REG_ADDR_W | Destination register of the decode instruction |
| decValid | input | 1 | Decode slot holds a real instruction |
| pcWrEn | output | 1 | Program counter may update |
| ifIdWrEn | output | 1 | Fetch/decode register may update |
| idExBubble | output | 1 | Replace the instruction entering execute with a no-operation |

## Verification
The bench builds the block with REG_ADDR_W=2, so there are four registers including register 0. This makes the sweep exhaustive. It covers every execute-stage destination, load flag and valid bit, crossed with every rs, rt, rt-read flag and store flag. That brings the register-0 exclusion, the store-data exemption and the rs-versus-rt priority within reach in a few thousand cycles. After each stalling case, the decode inputs are held across one more edge to show that the stall does not repeat.

// File: rtl/lu_pkg.sv
package lu_pkg;
  // Strobes from the hazard control to the execute-tag datapath and the top.
  typedef struct packed {
    logic holdPc;
    logic holdIfId;
    logic squashEx;
  } luStrobes_t;
endpackage

// File: rtl/lu_hazard_ctrl.sv
module lu_hazard_ctrl
  import lu_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] decRs,
  input  logic [REG_ADDR_W-1:0] decRt,
  input  logic                  decRtUsed,
  input  logic                  decIsStore,
  input  logic                  exValid,
  input  logic                  exIsLoad,
  input  logic [REG_ADDR_W-1:0] exRd,
  output luStrobes_t            strobes
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic pendingLoad;
  logic rsHit;
  logic rtHit;
  logic hazard;

  always_comb begin
    pendingLoad = exValid && exIsLoad && (exRd != ZERO_REG);
    rsHit       = (decRs == exRd);
    // Store data is picked up by the memory-stage bypass, so rt does not matter for a store.
    rtHit       = decRtUsed && !decIsStore && (decRt == exRd);
    hazard      = pendingLoad && (rsHit || rtHit);
    strobes.holdPc   = hazard;
    strobes.holdIfId = hazard;
    strobes.squashEx = hazard;
  end
endmodule

// File: rtl/lu_ex_tag.sv
module lu_ex_tag
  import lu_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  luStrobes_t            strobes,
  input  logic                  decValid,
  input  logic                  decIsLoad,
  input  logic [REG_ADDR_W-1:0] decRd,
  output logic                  exValid,
  output logic                  exIsLoad,
  output logic [REG_ADDR_W-1:0] exRd
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exValid  <= 1'b0;
      exIsLoad <= 1'b0;
      exRd     <= '0;
    end else if (strobes.squashEx) begin
      exValid  <= 1'b0;
      exIsLoad <= 1'b0;
      exRd     <= '0;
    end else begin
      exValid  <= decValid;
      exIsLoad <= decIsLoad;
      exRd     <= decRd;
    end
  end

  assert_bubble_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.squashEx |=> !exValid && !exIsLoad);

  assert_tag_advances_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.squashEx |=> (exValid == $past(decValid)) && (exIsLoad == $past(decIsLoad))
                          && (exRd == $past(decRd)));
endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
  import lu_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] decRs,
  input  logic [REG_ADDR_W-1:0] decRt,
  input  logic                  decRtUsed,
  input  logic                  decIsStore,
  input  logic                  decIsLoad,
  input  logic [REG_ADDR_W-1:0] decRd,
  input  logic                  decValid,
  output logic                  pcWrEn,
  output logic                  ifIdWrEn,
  output logic                  idExBubble
);
  luStrobes_t            strobes;
  logic                  exValid;
  logic                  exIsLoad;
  logic [REG_ADDR_W-1:0] exRd;

  lu_hazard_ctrl #(.REG_ADDR_W(REG_ADDR_W)) uCtrl (
    .decRs(decRs), .decRt(decRt), .decRtUsed(decRtUsed), .decIsStore(decIsStore),
    .exValid(exValid), .exIsLoad(exIsLoad), .exRd(exRd), .strobes(strobes)
  );

  lu_ex_tag #(.REG_ADDR_W(REG_ADDR_W)) uTag (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .decValid(decValid), .decIsLoad(decIsLoad), .decRd(decRd),
    .exValid(exValid), .exIsLoad(exIsLoad), .exRd(exRd)
  );

  assign pcWrEn     = !strobes.holdPc;
  assign ifIdWrEn   = !strobes.holdIfId;
  assign idExBubble = strobes.squashEx;

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |=> !idExBubble);

  assert_strobes_agree_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrEn == ifIdWrEn) && (pcWrEn != idExBubble));

  assert_rs_stalls_R1: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exIsLoad && exRd != '0 && decRs == exRd) |-> idExBubble);

  assert_store_data_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    (decIsStore && decRs != exRd) |-> !idExBubble);

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rstN)
    (exRd == '0) |-> !idExBubble);

  assert_needs_valid_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(exValid && exIsLoad) |-> !idExBubble);
endmodule

// File: tb/sim_lu_interlock.sv
module sim_lu_interlock;
  localparam int W = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] decRs = '0, decRt = '0, decRd = '0;
  logic decRtUsed = 1'b0, decIsStore = 1'b0, decIsLoad = 1'b0, decValid = 1'b0;
  logic pcWrEn, ifIdWrEn, idExBubble;
  int   testsRun = 0;
  int   testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lu_interlock #(.REG_ADDR_W(W)) u0 (
    .clk(clk), .rstN(rstN), .decRs(decRs), .decRt(decRt), .decRtUsed(decRtUsed),
    .decIsStore(decIsStore), .decIsLoad(decIsLoad), .decRd(decRd), .decValid(decValid),
    .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn), .idExBubble(idExBubble)
  );

  task automatic checkOut(input string req, input logic expStall);
    logic [2:0] act, exp;
    act = {pcWrEn, ifIdWrEn, idExBubble};
    exp = {!expStall, !expStall, expStall};
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: {pcWrEn,ifIdWrEn,idExBubble} actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive the decode fields just after a rising edge.
  task automatic driveDec(input logic v, input logic ld, input logic [W-1:0] rd,
                          input logic [W-1:0] rs, input logic [W-1:0] rt,
                          input logic used, input logic st);
    decValid = v; decIsLoad = ld; decRd = rd; decRs = rs; decRt = rt;
    decRtUsed = used; decIsStore = st;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R10: in reset, even with a would-be consumer on decode, no stall.
    driveDec(1, 1, 2'd1, 2'd1, 2'd1, 1, 0);
    repeat (2) @(posedge clk);
    @(negedge clk); checkOut("R10 reset", 1'b0);
    @(posedge clk); #1; rstN = 1'b1;
    // The decode load entered execute, so the same fields now stall (R9, R1).
    tick(); @(negedge clk); checkOut("R9 tag advanced", 1'b1);
    // Reset again with that load in flight: the tag must clear (R10).
    rstN = 1'b0; #1; checkOut("R10 reset clears tag", 1'b0);
    tick(); rstN = 1'b1; tick();

    // Exhaustive sweep of the execute tag against the decode fields.
    for (int exV = 0; exV < 2; exV++)
      for (int exL = 0; exL < 2; exL++)
        for (int exR = 0; exR < (1 << W); exR++)
          for (int rs = 0; rs < (1 << W); rs++)
            for (int rt = 0; rt < (1 << W); rt++)
              for (int used = 0; used < 2; used++)
                for (int st = 0; st < 2; st++) begin
                  logic expStall;
                  driveDec(0, 0, '0, '0, '0, 0, 0);
                  tick();                                   // empty execute
                  driveDec(exV[0], exL[0], exR[W-1:0], '0, '0, 0, 0);
                  tick();                                   // candidate into execute (R9)
                  driveDec(1, 0, '0, rs[W-1:0], rt[W-1:0], used[0], st[0]);
                  expStall = exV[0] && exL[0] && (exR != 0) &&
                             ((rs == exR) || (used[0] && !st[0] && (rt == exR)));
                  @(negedge clk);
                  if (exR == 0)                checkOut("R5 zero dest", expStall);
                  else if (!(exV[0] && exL[0])) checkOut("R6 not valid load", expStall);
                  else if (rs == exR)           checkOut("R1 rs match", expStall);
                  else if (st[0])               checkOut("R3 store data", expStall);
                  else if (!used[0])            checkOut("R4 rt unused", expStall);
                  else                          checkOut("R2 rt match / R7 strobes", expStall);
                  if (expStall) begin
                    tick();                                 // same decode held, bubble in EX
                    @(negedge clk); checkOut("R8 single-cycle stall", 1'b0);
                  end
                  @(posedge clk); #1;
                end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule